// File: doc/BRIEF.md
# Asynchronous serial receiver with break detection

This block receives asynchronous serial frames on a single input line. It does not generate its own baud timing. An enable that pulses sixteen times per bit period drives its timing. It accepts frames with 8 or 9 data slots. Parity is optional, and when it is used, the last data slot carries the parity bit. Each completed frame goes into a receive buffer and sets a buffer-full flag. The block also keeps sticky flags for framing errors, parity errors and line breaks. Software clears each flag by writing a one to the matching bit of the clear input.

A break is a low level that lasts at least a whole frame. A counter tracks the number of consecutive low bit periods, starting from the start bit. When break detection is enabled, the block separates two cases:

- **Low from the start bit.** If the line is low from the start bit onward, the frame is dropped without any trace and only the break flag rises.
- **Low from mid-frame.** If the line goes low partway through a frame, the partial frame is delivered with a framing error. The break flag follows once the low run is long enough.

After any frame that ends with a low stop bit, the receiver waits for the line to be high for a full bit period before it looks for a new start bit.

Top module: `brk_uart_rx`

## Requirements
- R1: Each bit is resolved by a two-of-three majority vote over the samples with index 7, 8 and 9 of the 16 samples in its bit period. Index 0 is the first low sample seen while idle. If the vote on the start bit comes out high, the start is abandoned with no effect on any output.
- R2: Frame layout and buffer layout:
  - A frame is a low start bit, then 8 data slots (or 9 when `cfg_nine` is 1) sent least significant first, then one stop bit.
  - The buffer holds slot i in `rx_data[i]`.
  - `rx_data[8]` reads 0 in 8-slot mode.
- R3: Parity checking when `cfg_par_en` is 1:
  - The last slot is the parity bit, and it is kept in the buffer.
  - `err_par` is set when the XOR of all slots differs from `cfg_par_odd` (0 selects even parity, 1 selects odd).
  - `err_par` is never set while `cfg_par_en` is 0.
- R4: A frame whose stop bit votes high loads the buffer, sets `rx_full` and leaves `err_frame` unchanged.
- R5: A frame whose stop bit votes low, and which is not a start-bit break under R7, loads the buffer, sets `rx_full` and sets `err_frame`.
- R6: The low-run counter starts at 1 on the start bit. It increments on every low bit period and restarts on any high one. The break threshold is 10 for 8-slot frames and 11 for 9-slot frames. A frame that is low only up to its last data slot, with a high stop bit, is a normal frame.
- R7: Start-bit break, with `cfg_brk_en` at 1, when the count reaches the threshold at the stop bit:
  - `rx_data` and `rx_full` are unchanged.
  - Neither error flag is set.
  - `brk_flag` is set.
- R8: Mid-frame break, with `cfg_brk_en` at 1, when the low level starts after the start bit:
  - At the stop bit the frame is loaded with `rx_full` and `err_frame` set, plus `err_par` under R3.
  - Bit periods keep being counted past the stop bit.
  - `brk_flag` is set when the count reaches the threshold.
- R9: With `cfg_brk_en` at 0, an all-low line is received as a frame of zeros with `err_frame` set, and `brk_flag` never rises.
- R10: After a break or a low stop bit, a new start bit is accepted only after 16 consecutive high samples. Lows seen before that are ignored.
- R11: Each bit of the write-one-to-clear input clears exactly one flag:
  - bit 0 clears `rx_full`
  - bit 1 clears `err_frame`
  - bit 2 clears `err_par`
  - bit 3 clears `brk_flag`
  
  A new setting event takes priority over a clear in the same cycle.
- R12: After reset, all flags and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Sample enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data slots |
| cfg_par_en | input | 1 | 1 enables parity checking on the last slot |
| cfg_par_odd | input | 1 | 1 selects odd parity |
| cfg_brk_en | input | 1 | 1 enables break detection |
| clr | input | 4 | Write-one-to-clear strobes for the flags |
| rx_data | output | 9 | Receive buffer |
| rx_full | output | 1 | Buffer holds a new frame |
| err_frame | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| brk_flag | output | 1 | Break detected flag |

## Verification
The checker watches the flag rules on every cycle:

- A load always raises `rx_full`.
- A break event always raises `brk_flag`.
- The buffer never changes without a load.
- A break and a load never coincide.
- A framing error only comes with a load.
- A parity error needs parity enabled.
- No break is reported while detection is off.
- Each clear bit drops its own flag.

Other behaviours depend on line timing and can only be shown by the bench's scenarios:

- the majority vote that rejects a short glitch;
- the two break thresholds at exactly the frame length;
- the difference between a start-bit break and a mid-frame break;
- the refusal to rearm before a full high bit period.

// File: rtl/brkrx_pkg.sv
package brkrx_pkg;
   localparam int unsigned SLOT_MAX = 9;

   localparam int unsigned CLR_FULL = 0;
   localparam int unsigned CLR_FE   = 1;
   localparam int unsigned CLR_PE   = 2;
   localparam int unsigned CLR_BRK  = 3;
   localparam int unsigned CLR_W    = 4;

   typedef enum logic [2:0] {
      ST_WAITHI,
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_BRK
   } rx_state_t;

   typedef struct packed {
      logic                load;
      logic [SLOT_MAX-1:0] data;
      logic                fe;
      logic                pe;
      logic                brk;
   } rx_evt_t;
endpackage

// File: rtl/brkrx_sync.sv
module brkrx_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{IDLE_VAL}};
            end else begin
               ff[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) begin
                  ff[i] <= ff[i-1];
               end
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/brkrx_sampler.sv
module brkrx_sampler #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_en,
   input  logic rx,
   input  logic run,
   input  logic start_go,
   output logic bit_stb,
   output logic bit_val
);
   localparam int unsigned PW  = $clog2(OVS);
   localparam int unsigned MID = OVS / 2;

   logic [PW-1:0] phase;
   logic          s_early;
   logic          s_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= '0;
         s_early <= 1'b1;
         s_mid   <= 1'b1;
      end else if (samp_en) begin
         if (start_go) begin
            phase <= PW'(1);
         end else if (run) begin
            phase <= (phase == PW'(OVS-1)) ? '0 : phase + PW'(1);
         end else begin
            phase <= '0;
         end
         if (run && phase == PW'(MID-1)) s_early <= rx;
         if (run && phase == PW'(MID))   s_mid   <= rx;
      end
   end

   assign bit_stb = samp_en && run && (phase == PW'(MID+1));
   assign bit_val = (s_early & s_mid) | (s_early & rx) | (s_mid & rx);
endmodule

// File: rtl/brkrx_frame.sv
module brkrx_frame
   import brkrx_pkg::*;
#(
   parameter int unsigned OVS        = 16,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    samp_en,
   input  logic    rx,
   input  logic    cfg_nine,
   input  logic    cfg_par_en,
   input  logic    cfg_par_odd,
   input  logic    cfg_brk_en,
   input  logic    bit_stb,
   input  logic    bit_val,
   output logic    run,
   output logic    start_go,
   output rx_evt_t evt
);
   localparam int unsigned ZW = $clog2(SLOT_MAX + 3);
   localparam int unsigned HW = $clog2(OVS + 1);
   localparam int unsigned SW = $clog2(SLOT_MAX);

   rx_state_t           st;
   logic [SW-1:0]       slot_idx;
   logic [SLOT_MAX-1:0] shreg;
   logic [ZW-1:0]       zrun;
   logic [HW-1:0]       hicnt;

   logic [SW-1:0] last_slot;
   logic [ZW-1:0] thr;
   logic [ZW-1:0] zinc;
   logic          parity_bad;

   assign last_slot = cfg_nine ? SW'(SLOT_MAX-1) : SW'(SLOT_MAX-2);
   assign thr       = cfg_nine ? ZW'(SLOT_MAX+2) : ZW'(SLOT_MAX+1);
   assign zinc      = zrun + ZW'(1);

   generate
      if (HAS_PARITY) begin : g_par
         assign parity_bad = cfg_par_en && ((^shreg) != cfg_par_odd);
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = cfg_par_en ^ cfg_par_odd;
         assign parity_bad = 1'b0;
      end
   endgenerate

   assign run      = (st == ST_START) || (st == ST_DATA) || (st == ST_STOP) || (st == ST_BRK);
   assign start_go = (st == ST_IDLE) && samp_en && !rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_WAITHI;
         slot_idx <= '0;
         shreg    <= '0;
         zrun     <= '0;
         hicnt    <= '0;
         evt      <= '0;
      end else begin
         evt <= '0;
         unique case (st)
            ST_WAITHI: begin
               if (samp_en) begin
                  if (!rx) begin
                     hicnt <= '0;
                  end else if (hicnt == HW'(OVS-1)) begin
                     hicnt <= '0;
                     st    <= ST_IDLE;
                  end else begin
                     hicnt <= hicnt + HW'(1);
                  end
               end
            end
            ST_IDLE: begin
               if (start_go) st <= ST_START;
            end
            ST_START: begin
               if (bit_stb) begin
                  if (!bit_val) begin
                     st       <= ST_DATA;
                     slot_idx <= '0;
                     shreg    <= '0;
                     zrun     <= ZW'(1);
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_DATA: begin
               if (bit_stb) begin
                  shreg[slot_idx] <= bit_val;
                  zrun            <= bit_val ? '0 : zinc;
                  if (slot_idx == last_slot) st <= ST_STOP;
                  else slot_idx <= slot_idx + SW'(1);
               end
            end
            ST_STOP: begin
               if (bit_stb) begin
                  if (bit_val) begin
                     evt.load <= 1'b1;
                     evt.data <= shreg;
                     evt.pe   <= parity_bad;
                     st       <= ST_IDLE;
                  end else if (cfg_brk_en && (zinc >= thr)) begin
                     evt.brk <= 1'b1;
                     hicnt   <= '0;
                     st      <= ST_WAITHI;
                  end else begin
                     evt.load <= 1'b1;
                     evt.data <= shreg;
                     evt.fe   <= 1'b1;
                     evt.pe   <= parity_bad;
                     zrun     <= zinc;
                     hicnt    <= '0;
                     st       <= cfg_brk_en ? ST_BRK : ST_WAITHI;
                  end
               end
            end
            ST_BRK: begin
               if (bit_stb) begin
                  if (bit_val) begin
                     hicnt <= '0;
                     st    <= ST_WAITHI;
                  end else if (zinc >= thr) begin
                     evt.brk <= 1'b1;
                     hicnt   <= '0;
                     st      <= ST_WAITHI;
                  end else begin
                     zrun <= zinc;
                  end
               end
            end
            default: st <= ST_WAITHI;
         endcase
      end
   end
endmodule

// File: rtl/brk_uart_rx.sv
module brk_uart_rx
   import brkrx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_PARITY  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                samp_en,
   input  logic                rx_in,
   input  logic                cfg_nine,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic                cfg_brk_en,
   input  logic [CLR_W-1:0]    clr,
   output logic [SLOT_MAX-1:0] rx_data,
   output logic                rx_full,
   output logic                err_frame,
   output logic                err_par,
   output logic                brk_flag
);
   generate
      if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("brk_uart_rx: OVS must be even and at least 8");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("brk_uart_rx: SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic    rx_s;
   logic    run;
   logic    start_go;
   logic    bit_stb;
   logic    bit_val;
   rx_evt_t frm_evt;

   brkrx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rx_s)
   );

   brkrx_sampler #(.OVS(OVS)) u_samp (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_en  (samp_en),
      .rx       (rx_s),
      .run      (run),
      .start_go (start_go),
      .bit_stb  (bit_stb),
      .bit_val  (bit_val)
   );

   brkrx_frame #(.OVS(OVS), .HAS_PARITY(HAS_PARITY)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .samp_en     (samp_en),
      .rx          (rx_s),
      .cfg_nine    (cfg_nine),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .cfg_brk_en  (cfg_brk_en),
      .bit_stb     (bit_stb),
      .bit_val     (bit_val),
      .run         (run),
      .start_go    (start_go),
      .evt         (frm_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_full   <= 1'b0;
         err_frame <= 1'b0;
         err_par   <= 1'b0;
         brk_flag  <= 1'b0;
      end else begin
         if (frm_evt.load) begin
            rx_data <= frm_evt.data;
            rx_full <= 1'b1;
         end else if (clr[CLR_FULL]) begin
            rx_full <= 1'b0;
         end
         if (frm_evt.fe)          err_frame <= 1'b1;
         else if (clr[CLR_FE])    err_frame <= 1'b0;
         if (frm_evt.pe)          err_par   <= 1'b1;
         else if (clr[CLR_PE])    err_par   <= 1'b0;
         if (frm_evt.brk)         brk_flag  <= 1'b1;
         else if (clr[CLR_BRK])   brk_flag  <= 1'b0;
      end
   end
endmodule

// File: rtl/brkrx_chk.sv
module brkrx_chk #(
   parameter int unsigned DW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_par_en,
   input logic          cfg_brk_en,
   input logic [3:0]    clr,
   input logic [DW-1:0] rx_data,
   input logic          rx_full,
   input logic          brk_flag,
   input logic          ev_load,
   input logic          ev_fe,
   input logic          ev_pe,
   input logic          ev_brk
);
   AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load |=> rx_full); // R4
   AST_FE_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ev_fe |-> ev_load); // R5
   AST_PE_NEEDS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pe |-> cfg_par_en); // R3
   AST_BRK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ev_brk |=> brk_flag); // R7
   AST_BRK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_brk && ev_load)); // R7
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_load |=> $stable(rx_data)); // R7
   AST_NO_BRK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_brk_en |-> !ev_brk); // R9
   AST_CLR_BRK: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[3] && !ev_brk) |=> !brk_flag); // R11
   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !clr[0]) |=> rx_full); // R11
endmodule

bind brk_uart_rx brkrx_chk #(.DW(brkrx_pkg::SLOT_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_par_en (cfg_par_en),
   .cfg_brk_en (cfg_brk_en),
   .clr        (clr),
   .rx_data    (rx_data),
   .rx_full    (rx_full),
   .brk_flag   (brk_flag),
   .ev_load    (frm_evt.load),
   .ev_fe      (frm_evt.fe),
   .ev_pe      (frm_evt.pe),
   .ev_brk     (frm_evt.brk)
);

// File: tb/tb_brk_uart_rx.sv
module tb_brk_uart_rx;
   localparam int CLK_PERIOD = 10;
   localparam int SPB        = 16;
   localparam int SAMP_DIV   = 2;
   localparam int BIT_CLKS   = SPB * SAMP_DIV;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       samp_en;
   logic       rx_in;
   logic       cfg_nine, cfg_par_en, cfg_par_odd, cfg_brk_en;
   logic [3:0] clr;
   logic [8:0] rx_data;
   logic       rx_full, err_frame, err_par, brk_flag;

   typedef struct {
      string      req;
      logic [8:0] data;
      logic       full;
      logic       fe;
      logic       pe;
      logic       brk;
   } exp_t;

   exp_t sbq[$];
   int   checks = 0;
   int   fails  = 0;
   int   pushed = 0;
   int   popped = 0;
   logic [8:0] last_data = '0;
   event settle_ev;

   brk_uart_rx dut (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_in(rx_in),
      .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_brk_en(cfg_brk_en), .clr(clr), .rx_data(rx_data), .rx_full(rx_full),
      .err_frame(err_frame), .err_par(err_par), .brk_flag(brk_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      samp_en = 1'b0;
      forever @(negedge clk) samp_en = ~samp_en;
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic line(logic v, int nbits);
      rx_in = v;
      repeat (nbits * BIT_CLKS) @(negedge clk);
   endtask

   task automatic frame(logic [8:0] slots, int nslots, logic stop);
      line(1'b0, 1);
      for (int i = 0; i < nslots; i++) line(slots[i], 1);
      line(stop, 1);
   endtask

   task automatic push(string req, logic [8:0] d, logic full, logic fe, logic pe, logic brk);
      exp_t e;
      e.req = req; e.data = d; e.full = full; e.fe = fe; e.pe = pe; e.brk = brk;
      sbq.push_back(e);
      pushed++;
      if (full) last_data = d;
   endtask

   task automatic clear_all();
      @(negedge clk) clr = 4'hF;
      @(negedge clk) clr = 4'h0;
   endtask

   task automatic settle(int idle_bits);
      line(1'b1, idle_bits);
      -> settle_ev;
      wait (popped == pushed);
      clear_all();
   endtask

   initial begin
      forever begin
         @(settle_ev);
         @(negedge clk);
         while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.req, "rx_data",   int'(rx_data),   int'(e.data));
            chk(e.req, "rx_full",   int'(rx_full),   int'(e.full));
            chk(e.req, "err_frame", int'(err_frame), int'(e.fe));
            chk(e.req, "err_par",   int'(err_par),   int'(e.pe));
            chk(e.req, "brk_flag",  int'(brk_flag),  int'(e.brk));
            popped++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rx_in = 1'b1; clr = 4'h0;
      cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_brk_en = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12", "rx_data",   int'(rx_data),   0);
      chk("R12", "rx_full",   int'(rx_full),   0);
      chk("R12", "err_frame", int'(err_frame), 0);
      chk("R12", "err_par",   int'(err_par),   0);
      chk("R12", "brk_flag",  int'(brk_flag),  0);
      line(1'b1, 2);

      // R2 R4: plain 8-slot frame
      frame(9'h0A5, 8, 1'b1);
      push("R4", 9'h0A5, 1, 0, 0, 0);
      settle(3);

      // R2: 9-slot frame
      cfg_nine = 1'b1;
      frame(9'h1C3, 9, 1'b1);
      push("R2", 9'h1C3, 1, 0, 0, 0);
      settle(3);

      // R6 R7: 9-slot start-bit break exactly at 11 low periods
      line(1'b0, 11);
      push("R7", last_data, 0, 0, 0, 1);
      settle(3);

      // R6: 10 low periods then a high stop is a normal 9-slot frame
      line(1'b0, 10);
      push("R6", 9'h000, 1, 0, 0, 0);
      settle(3);

      // R3: parity, 8-slot mode
      cfg_nine = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      frame(9'h035, 8, 1'b1);
      push("R3", 9'h035, 1, 0, 0, 0);
      settle(3);
      frame(9'h0B5, 8, 1'b1);
      push("R3", 9'h0B5, 1, 0, 1, 0);
      settle(3);
      cfg_par_odd = 1'b1;
      frame(9'h0B5, 8, 1'b1);
      push("R3", 9'h0B5, 1, 0, 0, 0);
      settle(3);

      // R8: low begins after slot 0, even parity wrong
      cfg_par_odd = 1'b0;
      line(1'b0, 1);
      line(1'b1, 1);
      line(1'b0, 14);
      push("R8", 9'h001, 1, 1, 1, 1);
      settle(3);

      // R6 R7: 8-slot start-bit break at exactly 10 low periods
      cfg_par_en = 1'b0;
      line(1'b0, 10);
      push("R7", last_data, 0, 0, 0, 1);
      settle(3);

      // R9: break detection off
      cfg_brk_en = 1'b0;
      line(1'b0, 13);
      push("R9", 9'h000, 1, 1, 0, 0);
      settle(3);

      // R1: short low glitch is rejected, following frame is received
      rx_in = 1'b0;
      repeat (4 * SAMP_DIV) @(negedge clk);
      line(1'b1, 2);
      frame(9'h05A, 8, 1'b1);
      push("R1", 9'h05A, 1, 0, 0, 0);
      settle(3);

      // R5 R10: low stop, then lows before a full high bit are ignored
      frame(9'h081, 8, 1'b0);
      line(1'b0, 1);
      rx_in = 1'b1;
      repeat (BIT_CLKS / 2) @(negedge clk);
      line(1'b0, 2);
      push("R10", 9'h081, 1, 1, 0, 0);
      settle(12);

      // R11: each clear bit drops only its own flag
      cfg_brk_en = 1'b1;
      line(1'b0, 1);
      line(1'b1, 1);
      line(1'b0, 14);
      line(1'b1, 3);
      @(negedge clk);
      chk("R11", "setup err_frame", int'(err_frame), 1);
      chk("R11", "setup brk_flag",  int'(brk_flag),  1);
      clr = 4'b0001; @(negedge clk); clr = 4'h0; @(negedge clk);
      chk("R11", "rx_full after clr0",   int'(rx_full),   0);
      chk("R11", "err_frame after clr0", int'(err_frame), 1);
      clr = 4'b0010; @(negedge clk); clr = 4'h0; @(negedge clk);
      chk("R11", "err_frame after clr1", int'(err_frame), 0);
      chk("R11", "brk_flag after clr1",  int'(brk_flag),  1);
      clr = 4'b1000; @(negedge clk); clr = 4'h0; @(negedge clk);
      chk("R11", "brk_flag after clr3",  int'(brk_flag),  0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule